// File: doc/BRIEF.md
# Two-Class QoS Command Arbiter

This block holds a small pool of pending memory commands and picks the next one to issue each cycle. Every command carries an address, a read/write flag and a one-bit priority class. The priority comes from the QoS field of the AXI address channel the command arrived on: AW for writes, AR for reads. Class 1 is high priority and class 0 is normal. Commands enter through a valid/ready port into the lowest free slot. One granted command is presented per cycle on a second valid/ready port.

High-priority commands win over normal ones. Within a class, service rotates round-robin from a per-class pointer. Every waiting command has an age counter. Once a normal command's age reaches the programmable `ageLimit`, it is promoted above all high-priority traffic, so normal commands cannot starve. DRAM timing, bank state, data paths and read reordering are handled elsewhere.

Top module: `qos_cmd_arbiter`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `outValid` is 0, `inReady` is 1, and both round-robin pointers are at slot 0.
- R2: When `inValid && inReady` is true at a clock edge, the command is stored in the lowest-numbered free slot. It can be granted from the following cycle. `outAddr`, `outWrite` and `outQos` show the fields of the granted slot.
- R3: When all `SLOTS` entries are occupied, `inReady` is 0 and a command offered on `inValid` is discarded. It never appears at the output.
- R4: When no normal command is aged, any valid high-priority command (`inQos`=1) is granted before every normal command.
- R5: Within a class, the grant goes to the first valid slot of that class at or after the class pointer, in ascending index order, wrapping from `SLOTS`-1 back to 0.
- R6: A class pointer moves to the slot after the granted slot, only at an edge where `outValid && outReady` is true and the grant came from that class. A promoted normal grant moves the normal pointer. Otherwise both pointers hold, including while the pool is empty.
- R7: Each occupied slot's age rises by one per cycle. A normal command whose age is at least `ageLimit` is aged and beats every high-priority command. Among aged commands, the largest age wins, and a tie goes to the lowest slot.
- R8: Ages saturate at 2^`AGE_W`-1 instead of wrapping. An age is cleared to 0 when its slot is loaded or granted.
- R9: When the pool is empty, `outValid` is 0.
- R10: A slot whose command is accepted at the output is freed at that edge. It can be refilled from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| ageLimit | input | AGE_W | Age at which a normal command is promoted |
| inValid | input | 1 | Incoming command is valid |
| inReady | output | 1 | A free slot exists |
| inAddr | input | ADDR_W | Incoming command address |
| inWrite | input | 1 | 1 = write (from AW), 0 = read (from AR) |
| inQos | input | 1 | Priority class: 1 high, 0 normal |
| outValid | output | 1 | A granted command is presented |
| outReady | input | 1 | Downstream takes the granted command |
| outAddr | output | ADDR_W | Address of granted command |
| outWrite | output | 1 | Read/write flag of granted command |
| outQos | output | 1 | Class of granted command |

## Verification
The bench fills the pool with mixed classes and drains it. This checks that high commands go first in rotating order and that an offer made while full is lost rather than stored. A design that grants a flat round-robin across classes would interleave the two classes. A design that moves a pointer on a stalled grant, or fails to wrap it past the top slot, returns addresses out of the expected rotation. Aging is tested in three ways. A normal command is made to overtake a waiting high one. Two aged commands are raced so that the oldest wins over the one the pointer favours. A command is held past 2^`AGE_W` cycles against the maximum limit, so a wrapping counter would leave it stuck behind the high command. A refill after a grant checks that ages start over from zero.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;

  // Source of the current grant decision.
  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_AGED,
    SRC_HIGH,
    SRC_NORM
  } grant_src_e;

  // Strobes driven by the control into the slot pool.
  typedef struct packed {
    logic load;   // store incoming command into loadIdx
    logic grant;  // granted command at grantIdx was taken
  } strobe_t;

endpackage

// File: rtl/qos_arb_pool.sv
module qos_arb_pool
  import qos_arb_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 32,
  parameter int AGE_W  = 6,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strb,
  input  logic [IDX_W-1:0]             loadIdx,
  input  logic [IDX_W-1:0]             grantIdx,
  input  logic [ADDR_W-1:0]            inAddr,
  input  logic                         inWrite,
  input  logic                         inQos,
  output logic [SLOTS-1:0]             validVec,
  output logic [SLOTS-1:0]             qosVec,
  output logic [SLOTS-1:0][AGE_W-1:0]  ageVec,
  output logic [ADDR_W-1:0]            outAddr,
  output logic                         outWrite,
  output logic                         outQos
);

  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic [SLOTS-1:0][ADDR_W-1:0] addrMem;
  logic [SLOTS-1:0]             writeMem;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic loadHere;
    logic grantHere;

    assign loadHere  = strb.load  && (loadIdx  == IDX_W'(i));
    assign grantHere = strb.grant && (grantIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validVec[i] <= 1'b0;
        qosVec[i]   <= 1'b0;
        ageVec[i]   <= '0;
      end else if (loadHere) begin
        validVec[i] <= 1'b1;
        qosVec[i]   <= inQos;
        ageVec[i]   <= '0;
      end else if (grantHere) begin
        validVec[i] <= 1'b0;
        ageVec[i]   <= '0;
      end else if (validVec[i] && (ageVec[i] != AGE_MAX)) begin
        ageVec[i]   <= ageVec[i] + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (loadHere) begin
        addrMem[i]  <= inAddr;
        writeMem[i] <= inWrite;
      end
    end
  end

  assign outAddr  = addrMem[grantIdx];
  assign outWrite = writeMem[grantIdx];
  assign outQos   = qosVec[grantIdx];

endmodule

// File: rtl/qos_arb_ctrl.sv
module qos_arb_ctrl
  import qos_arb_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int AGE_W  = 6,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [AGE_W-1:0]             ageLimit,
  input  logic                         inValid,
  output logic                         inReady,
  output logic                         outValid,
  input  logic                         outReady,
  input  logic [SLOTS-1:0]             validVec,
  input  logic [SLOTS-1:0]             qosVec,
  input  logic [SLOTS-1:0][AGE_W-1:0]  ageVec,
  output strobe_t                      strb,
  output logic [IDX_W-1:0]             loadIdx,
  output logic [IDX_W-1:0]             grantIdx,
  output logic [IDX_W-1:0]             hiPtr,
  output logic [IDX_W-1:0]             loPtr
);

  logic [SLOTS-1:0] agedVec;
  logic [SLOTS-1:0] hiMask;
  logic [SLOTS-1:0] loMask;

  for (genvar i = 0; i < SLOTS; i++) begin : g_class
    assign hiMask[i]  = validVec[i] &&  qosVec[i];
    assign loMask[i]  = validVec[i] && !qosVec[i];
    assign agedVec[i] = loMask[i] && (ageVec[i] >= ageLimit);
  end

  // First set bit of mask at or after ptr, wrapping.
  function automatic logic [IDX_W:0] rrPick(input logic [SLOTS-1:0] mask,
                                            input logic [IDX_W-1:0] ptr);
    logic             hit;
    logic [IDX_W-1:0] idx;
    hit = 1'b0;
    idx = '0;
    for (int k = 0; k < SLOTS; k++) begin
      int j;
      j = (int'(ptr) + k) % SLOTS;
      if (!hit && mask[j]) begin
        hit = 1'b1;
        idx = IDX_W'(j);
      end
    end
    return {hit, idx};
  endfunction

  function automatic logic [IDX_W-1:0] nextSlot(input logic [IDX_W-1:0] s);
    return (s == IDX_W'(SLOTS - 1)) ? '0 : s + 1'b1;
  endfunction

  logic             hiHit, loHit, agedHit;
  logic [IDX_W-1:0] hiIdx, loIdx, agedIdx;
  logic [AGE_W-1:0] bestAge;
  grant_src_e       src;

  assign {hiHit, hiIdx} = rrPick(hiMask, hiPtr);
  assign {loHit, loIdx} = rrPick(loMask, loPtr);

  // Oldest aged normal command; strict compare keeps lowest slot on a tie.
  always_comb begin
    agedHit = 1'b0;
    agedIdx = '0;
    bestAge = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (agedVec[i] && (!agedHit || ageVec[i] > bestAge)) begin
        agedHit = 1'b1;
        agedIdx = IDX_W'(i);
        bestAge = ageVec[i];
      end
    end
  end

  always_comb begin
    src      = SRC_NONE;
    grantIdx = '0;
    if (agedHit) begin
      src      = SRC_AGED;
      grantIdx = agedIdx;
    end else if (hiHit) begin
      src      = SRC_HIGH;
      grantIdx = hiIdx;
    end else if (loHit) begin
      src      = SRC_NORM;
      grantIdx = loIdx;
    end
  end

  // Lowest free slot for the next load.
  always_comb begin
    loadIdx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!validVec[i]) loadIdx = IDX_W'(i);
    end
  end

  assign inReady    = !(&validVec);
  assign outValid   = (src != SRC_NONE);
  assign strb.load  = inValid && inReady;
  assign strb.grant = outValid && outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiPtr <= '0;
      loPtr <= '0;
    end else if (strb.grant) begin
      if (src == SRC_HIGH) hiPtr <= nextSlot(grantIdx);
      else                 loPtr <= nextSlot(grantIdx);
    end
  end

endmodule

// File: rtl/qos_cmd_arbiter.sv
module qos_cmd_arbiter
  import qos_arb_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 32,
  parameter int AGE_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AGE_W-1:0]  ageLimit,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              inWrite,
  input  logic              inQos,
  output logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outWrite,
  output logic              outQos
);

  localparam int IDX_W = $clog2(SLOTS);

  strobe_t                     strb;
  logic [IDX_W-1:0]            loadIdx;
  logic [IDX_W-1:0]            grantIdx;
  logic [IDX_W-1:0]            hiPtr;
  logic [IDX_W-1:0]            loPtr;
  logic [SLOTS-1:0]            validVec;
  logic [SLOTS-1:0]            qosVec;
  logic [SLOTS-1:0][AGE_W-1:0] ageVec;

  qos_arb_ctrl #(.SLOTS(SLOTS), .AGE_W(AGE_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ageLimit (ageLimit),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .validVec (validVec),
    .qosVec   (qosVec),
    .ageVec   (ageVec),
    .strb     (strb),
    .loadIdx  (loadIdx),
    .grantIdx (grantIdx),
    .hiPtr    (hiPtr),
    .loPtr    (loPtr)
  );

  qos_arb_pool #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_pool (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .loadIdx  (loadIdx),
    .grantIdx (grantIdx),
    .inAddr   (inAddr),
    .inWrite  (inWrite),
    .inQos    (inQos),
    .validVec (validVec),
    .qosVec   (qosVec),
    .ageVec   (ageVec),
    .outAddr  (outAddr),
    .outWrite (outWrite),
    .outQos   (outQos)
  );

endmodule

// File: rtl/qos_arb_checker.sv
module qos_arb_checker #(
  parameter int SLOTS = 8,
  parameter int AGE_W = 6,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int OCC_W = $clog2(SLOTS + 1)
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         inValid,
  input logic                         inReady,
  input logic                         outValid,
  input logic                         outReady,
  input logic                         outQos,
  input logic [AGE_W-1:0]             ageLimit,
  input logic [SLOTS-1:0]             validVec,
  input logic [SLOTS-1:0]             qosVec,
  input logic [SLOTS-1:0][AGE_W-1:0]  ageVec,
  input logic [IDX_W-1:0]             hiPtr,
  input logic [IDX_W-1:0]             loPtr
);

  // Occupancy tracked only from the two handshakes.
  logic [OCC_W-1:0] occ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) occ <= '0;
    else occ <= occ + OCC_W'(inValid && inReady) - OCC_W'(outValid && outReady);
  end

  logic anyAged;
  logic anyHigh;
  always_comb begin
    anyAged = 1'b0;
    anyHigh = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (validVec[i] && !qosVec[i] && ageVec[i] >= ageLimit) anyAged = 1'b1;
      if (validVec[i] && qosVec[i]) anyHigh = 1'b1;
    end
  end

  p_full_stalls_r3: assert property (@(posedge clk) disable iff (!rstN)
    (occ == OCC_W'(SLOTS)) |-> !inReady);

  p_empty_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (occ == '0) |-> !outValid);

  p_high_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !anyAged && anyHigh) |-> outQos);

  p_aged_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && anyAged) |-> !outQos);

  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && outReady) |=> ($stable(hiPtr) && $stable(loPtr)));

endmodule

bind qos_cmd_arbiter qos_arb_checker #(.SLOTS(SLOTS), .AGE_W(AGE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outQos   (outQos),
  .ageLimit (ageLimit),
  .validVec (validVec),
  .qosVec   (qosVec),
  .ageVec   (ageVec),
  .hiPtr    (hiPtr),
  .loPtr    (loPtr)
);

// File: tb/test_qos_cmd_arbiter.sv
module test_qos_cmd_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int SLOTS  = 8;
  localparam int ADDR_W = 32;
  localparam int AGE_W  = 6;

  // Vector: {addr[7:0], write, qos, expected drain slot[2:0]}
  localparam logic [12:0] VEC [8] = '{
    {8'h10, 1'b0, 1'b0, 3'd1},
    {8'h11, 1'b1, 1'b1, 3'd4},
    {8'h12, 1'b0, 1'b0, 3'd6},
    {8'h13, 1'b1, 1'b0, 3'd0},
    {8'h14, 1'b0, 1'b1, 3'd2},
    {8'h15, 1'b1, 1'b0, 3'd3},
    {8'h16, 1'b0, 1'b1, 3'd5},
    {8'h17, 1'b1, 1'b0, 3'd7}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [AGE_W-1:0]  ageLimit = '1;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [ADDR_W-1:0] inAddr = '0;
  logic              inWrite = 1'b0;
  logic              inQos = 1'b0;
  logic              outValid;
  logic              outReady = 1'b0;
  logic [ADDR_W-1:0] outAddr;
  logic              outWrite;
  logic              outQos;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  qos_cmd_arbiter #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .AGE_W(AGE_W)) i_qos_cmd_arbiter (
    .clk(clk), .rstN(rstN), .ageLimit(ageLimit),
    .inValid(inValid), .inReady(inReady), .inAddr(inAddr),
    .inWrite(inWrite), .inQos(inQos),
    .outValid(outValid), .outReady(outReady), .outAddr(outAddr),
    .outWrite(outWrite), .outQos(outQos)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadCmd(input logic [7:0] a, input logic w, input logic q);
    inValid = 1'b1;
    inAddr  = {24'h0, a};
    inWrite = w;
    inQos   = q;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic takeExp(input logic [7:0] a, input string req);
    chk(outValid, req, 32'(outValid), 32'd1);
    chk(outAddr == {24'h0, a}, req, outAddr, {24'h0, a});
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!outValid, "R1 outValid in reset", 32'(outValid), 0);
    chk(inReady, "R1 inReady in reset", 32'(inReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    chk(!outValid, "R1 outValid after reset", 32'(outValid), 0);
    chk(inReady, "R1 inReady after reset", 32'(inReady), 1);

    // Table: fill all slots with mixed classes (R2), then check full (R3)
    for (int k = 0; k < 8; k++) begin
      chk(inReady, "R2 inReady while filling", 32'(inReady), 1);
      loadCmd(VEC[k][12:5], VEC[k][4], VEC[k][3]);
    end
    chk(!inReady, "R3 inReady when full", 32'(inReady), 0);
    inValid = 1'b1; inAddr = 32'h99; inQos = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk(!inReady, "R3 still full after offer", 32'(inReady), 0);
    // Drain: highs first round-robin (R4, R5), then normals (R5)
    for (int k = 0; k < 8; k++) begin
      int s;
      s = int'(VEC[k][2:0]);
      chk(outWrite == VEC[s][4], "R2 outWrite", 32'(outWrite), 32'(VEC[s][4]));
      chk(outQos == VEC[s][3], "R4 outQos order", 32'(outQos), 32'(VEC[s][3]));
      takeExp(VEC[s][12:5], "R5 drain order");
    end
    chk(!outValid, "R9 empty after drain (R3 dropped offer)", 32'(outValid), 0);

    // Pointer hold and wrap within normal class (R6, R5, R10)
    for (int k = 0; k < 4; k++) loadCmd(8'h20 + 8'(k), 1'b0, 1'b0);
    repeat (3) begin
      chk(outAddr == 32'h20, "R6 hold while stalled", outAddr, 32'h20);
      @(negedge clk);
    end
    takeExp(8'h20, "R6 first normal");
    loadCmd(8'h24, 1'b1, 1'b0);
    takeExp(8'h21, "R6 pointer advanced");
    takeExp(8'h22, "R5 rotate");
    takeExp(8'h23, "R5 rotate");
    takeExp(8'h24, "R10 reused slot wraps");
    repeat (2) @(negedge clk);
    chk(!outValid, "R9 empty idle", 32'(outValid), 0);

    // High pointer wraps from slot 7 (R5), high before normal (R4)
    loadCmd(8'h30, 1'b0, 1'b0);
    loadCmd(8'h31, 1'b0, 1'b1);
    loadCmd(8'h32, 1'b1, 1'b1);
    takeExp(8'h31, "R5 high wrap");
    takeExp(8'h32, "R4 high next");
    takeExp(8'h30, "R4 normal last");

    // Aging promotes a normal command (R7)
    ageLimit = 6'd5;
    loadCmd(8'h40, 1'b0, 1'b0);
    loadCmd(8'h41, 1'b0, 1'b1);
    chk(outAddr == 32'h41, "R4 high before aging", outAddr, 32'h41);
    repeat (10) @(negedge clk);
    takeExp(8'h40, "R7 aged beats high");
    takeExp(8'h41, "R7 high after aged");

    // Oldest aged wins over pointer choice (R7)
    loadCmd(8'h50, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    loadCmd(8'h51, 1'b0, 1'b0);
    loadCmd(8'h52, 1'b0, 1'b1);
    repeat (15) @(negedge clk);
    takeExp(8'h50, "R7 oldest aged");
    takeExp(8'h51, "R7 second aged");
    takeExp(8'h52, "R7 high last");

    // Saturation at maximum limit (R8)
    ageLimit = '1;
    loadCmd(8'h60, 1'b0, 1'b0);
    loadCmd(8'h61, 1'b0, 1'b1);
    chk(outAddr == 32'h61, "R8 young normal waits", outAddr, 32'h61);
    repeat (70) @(negedge clk);
    takeExp(8'h60, "R8 saturated age promotes");
    takeExp(8'h61, "R8 high after");

    // Age cleared on grant and load (R8)
    loadCmd(8'h70, 1'b0, 1'b0);
    loadCmd(8'h71, 1'b0, 1'b1);
    chk(outAddr == 32'h71, "R8 age restarted", outAddr, 32'h71);
    takeExp(8'h71, "R8 high");
    takeExp(8'h70, "R8 normal");
    chk(!outValid, "R9 final empty", 32'(outValid), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule